// File: doc/BRIEF.md
# Egress Timestamp FIFO

This block keeps the transmit timestamps of outgoing precision-time event messages until the host collects them. Each capture strobe carries a message's domain number, message type, sequence ID and departure time, given as seconds, nanoseconds and a 16-bit sub-nanosecond fraction. The block adds a programmable transmit pipeline delay to the time and queues the result in a small FIFO. A full FIFO drops the new capture and raises a sticky overflow flag.

The host collects entries through a small register window. A write of the done bit moves the oldest queued entry into a readout slot. That slot is then read as four 16-bit words, and word 0 carries a valid flag. The host repeats the done-then-read sequence until the valid flag reads 0. It can start this sequence from a level interrupt, which needs no acknowledge and stays high while entries are queued. It can also start it from polling.

Top module: `egress_ts_fifo`

## Requirements
- R1: After reset all four readout words read 0, `irq` is low, and the interrupt enable (address 5), status (address 6) and both delay registers (addresses 7 and 8) read 0.
- R2: Readout word 0 (address 0) holds the domain number in [7:0], the message type in [11:8], seconds bits 4:2 in [14:12] and the valid flag in [15]. Word 1 (address 1) holds the 16-bit sequence ID.
- R3: Word 2 (address 2) holds nanoseconds [15:0]. Word 3 (address 3) holds nanoseconds [29:16] in [13:0] and seconds [1:0] in [15:14].
- R4: A write with bit 0 set to the ring-control register (address 4) loads the oldest queued entry into the readout slot, so entries come out in capture order. If nothing is queued, that write clears the slot, and all four words then read 0, valid included.
- R5: `irq` equals interrupt-enable bit 0 (address 5) ANDed with "FIFO not empty". It has no acknowledge and stays high until the last queued entry has been moved to the readout slot.
- R6: Status bit 0 (address 6) reads 1 while the FIFO holds an entry, whatever the enable is. This allows polling.
- R7: The stored time is the captured time plus the delay in whole nanoseconds (address 7) plus the delay fraction in 1/65536 ns (address 8). The fraction sum carries into the nanoseconds and is then discarded.
- R8: When the delayed nanoseconds reach 1,000,000,000, the block subtracts 10^9 from them and adds 1 to the 5-bit seconds, modulo 32.
- R9: A capture while DEPTH (default 4) entries are queued is dropped, and earlier entries stay intact. The drop sets the sticky status bit 1, which is cleared only by writing 1 to status bit 1.
- R10: A write to address 4 with bit 0 clear changes neither the readout slot nor the FIFO.
- R11: A capture is queued at the next clock edge. A capture and a done write in the same cycle are both carried out, and the done acts on the FIFO content from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Capture strobe, one cycle per transmitted event message |
| cap_domain | input | 8 | Domain number of the message |
| cap_msg_type | input | 4 | Message type |
| cap_seq_id | input | 16 | Sequence ID |
| cap_sec | input | 5 | Low seconds bits of departure time |
| cap_nsec | input | 30 | Nanoseconds of departure time (below 10^9) |
| cap_subns | input | 16 | Sub-nanosecond fraction of departure time |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data for host_addr (combinational) |
| irq | output | 1 | Level interrupt, enabled FIFO not empty |

## Verification
On every cycle the assertions check four things. The FIFO fill never goes above its depth and moves by at most one step per cycle. A capture into a full FIFO leaves the fill unchanged. `irq` never stays high without a queued entry, and it never drops without a done write or an enable write. An invalid readout slot always shows four zero words. The bench scenarios are needed for the rest. They show the word packing, the delay addition with its fraction carry and the nanosecond wrap, the first-in first-out order, the sticky overflow and how it is cleared, and the ordering when a capture and a done fall in the same cycle.

// File: rtl/ets_pkg.sv
package ets_pkg;
  localparam int DOM_W  = 8;
  localparam int TYP_W  = 4;
  localparam int SEQ_W  = 16;
  localparam int SEC_W  = 5;
  localparam int NS_W   = 30;
  localparam int FRAC_W = 16;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int DLY_W  = 16;

  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1000000000;

  localparam logic [ADDR_W-1:0] A_WORD0  = 4'd0;
  localparam logic [ADDR_W-1:0] A_WORD1  = 4'd1;
  localparam logic [ADDR_W-1:0] A_WORD2  = 4'd2;
  localparam logic [ADDR_W-1:0] A_WORD3  = 4'd3;
  localparam logic [ADDR_W-1:0] A_RING   = 4'd4;
  localparam logic [ADDR_W-1:0] A_IRQ_EN = 4'd5;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd6;
  localparam logic [ADDR_W-1:0] A_DLY_NS = 4'd7;
  localparam logic [ADDR_W-1:0] A_DLY_FR = 4'd8;

  typedef struct packed {
    logic [DOM_W-1:0] domain;
    logic [TYP_W-1:0] msg_type;
    logic [SEQ_W-1:0] seq_id;
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  nsec;
  } ets_entry_t;
endpackage

// File: rtl/ets_delay_add.sv
module ets_delay_add
  import ets_pkg::*;
(
  input  ets_entry_t         raw_i,
  input  logic [FRAC_W-1:0]  raw_frac_i,
  input  logic [DLY_W-1:0]   dly_ns_i,
  input  logic [FRAC_W-1:0]  dly_frac_i,
  output ets_entry_t         adj_o
);
  localparam int PAD_W = NS_W + 1 - DLY_W;

  logic            frac_carry;
  logic [NS_W:0]   ns_sum;
  logic            ns_wrap;

  always_comb begin
    // fraction overflow occurs exactly when a + b >= 2^FRAC_W
    frac_carry = (raw_frac_i > ~dly_frac_i);
    ns_sum     = {1'b0, raw_i.nsec} + {{PAD_W{1'b0}}, dly_ns_i}
               + {{NS_W{1'b0}}, frac_carry};
    ns_wrap    = (ns_sum >= {1'b0, NS_PER_SEC});

    adj_o          = raw_i;
    adj_o.nsec     = ns_wrap ? NS_W'(ns_sum - {1'b0, NS_PER_SEC}) : ns_sum[NS_W-1:0];
    adj_o.sec      = raw_i.sec + SEC_W'(ns_wrap);
  end
endmodule

// File: rtl/ets_fifo.sv
module ets_fifo
  import ets_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  ets_entry_t       din_i,
  input  logic             pop_i,
  output ets_entry_t       head_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  ets_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_comb begin
    wr_ptr_d = do_push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_pop  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_ptr_q == PTR_W'(g))) begin
        mem[g] <= din_i;
      end
    end
  end

  assign head_o = mem[rd_ptr_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ets_regs.sv
module ets_regs
  import ets_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  input  logic               fifo_empty_i,
  input  ets_entry_t         head_i,
  input  logic               ovf_set_i,
  output logic               pop_o,
  output logic [DLY_W-1:0]   dly_ns_o,
  output logic [FRAC_W-1:0]  dly_frac_o,
  output logic               rdo_valid_o,
  output logic [WORD_W-1:0]  word0_o,
  output logic [WORD_W-1:0]  word1_o,
  output logic [WORD_W-1:0]  word2_o,
  output logic [WORD_W-1:0]  word3_o,
  output logic [WORD_W-1:0]  host_rdata,
  output logic               irq_o
);
  ets_entry_t        rdo_q, rdo_d;
  logic              rdo_vld_q, rdo_vld_d;
  logic              irq_en_q, irq_en_d;
  logic              ovf_q, ovf_d;
  logic [DLY_W-1:0]  dly_ns_q, dly_ns_d;
  logic [FRAC_W-1:0] dly_fr_q, dly_fr_d;
  logic              wr_ring, wr_en, wr_stat, wr_dns, wr_dfr;

  always_comb begin
    wr_ring = host_wr && (host_addr == A_RING);
    wr_en   = host_wr && (host_addr == A_IRQ_EN);
    wr_stat = host_wr && (host_addr == A_STATUS);
    wr_dns  = host_wr && (host_addr == A_DLY_NS);
    wr_dfr  = host_wr && (host_addr == A_DLY_FR);
    pop_o   = wr_ring && host_wdata[0];
  end

  always_comb begin
    rdo_d     = rdo_q;
    rdo_vld_d = rdo_vld_q;
    if (pop_o) begin
      if (!fifo_empty_i) begin
        rdo_d     = head_i;
        rdo_vld_d = 1'b1;
      end else begin
        rdo_d     = '0;
        rdo_vld_d = 1'b0;
      end
    end
    irq_en_d = wr_en  ? host_wdata[0] : irq_en_q;
    dly_ns_d = wr_dns ? host_wdata    : dly_ns_q;
    dly_fr_d = wr_dfr ? host_wdata    : dly_fr_q;
    if (ovf_set_i) begin
      ovf_d = 1'b1;
    end else if (wr_stat && host_wdata[1]) begin
      ovf_d = 1'b0;
    end else begin
      ovf_d = ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdo_q     <= '0;
      rdo_vld_q <= 1'b0;
      irq_en_q  <= 1'b0;
      ovf_q     <= 1'b0;
      dly_ns_q  <= '0;
      dly_fr_q  <= '0;
    end else begin
      rdo_q     <= rdo_d;
      rdo_vld_q <= rdo_vld_d;
      irq_en_q  <= irq_en_d;
      ovf_q     <= ovf_d;
      dly_ns_q  <= dly_ns_d;
      dly_fr_q  <= dly_fr_d;
    end
  end

  always_comb begin
    word0_o = {rdo_vld_q, rdo_q.sec[4:2], rdo_q.msg_type, rdo_q.domain};
    word1_o = rdo_q.seq_id;
    word2_o = rdo_q.nsec[15:0];
    word3_o = {rdo_q.sec[1:0], rdo_q.nsec[29:16]};
    unique case (host_addr)
      A_WORD0:  host_rdata = word0_o;
      A_WORD1:  host_rdata = word1_o;
      A_WORD2:  host_rdata = word2_o;
      A_WORD3:  host_rdata = word3_o;
      A_IRQ_EN: host_rdata = {{(WORD_W-1){1'b0}}, irq_en_q};
      A_STATUS: host_rdata = {{(WORD_W-2){1'b0}}, ovf_q, !fifo_empty_i};
      A_DLY_NS: host_rdata = dly_ns_q;
      A_DLY_FR: host_rdata = dly_fr_q;
      default:  host_rdata = '0;
    endcase
  end

  assign rdo_valid_o = rdo_vld_q;
  assign dly_ns_o    = dly_ns_q;
  assign dly_frac_o  = dly_fr_q;
  assign irq_o       = irq_en_q && !fifo_empty_i;
endmodule

// File: rtl/egress_ts_fifo.sv
module egress_ts_fifo
  import ets_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_valid,
  input  logic [DOM_W-1:0]   cap_domain,
  input  logic [TYP_W-1:0]   cap_msg_type,
  input  logic [SEQ_W-1:0]   cap_seq_id,
  input  logic [SEC_W-1:0]   cap_sec,
  input  logic [NS_W-1:0]    cap_nsec,
  input  logic [FRAC_W-1:0]  cap_subns,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  output logic               irq
);
  ets_entry_t        raw_entry, adj_entry, head_entry;
  logic [DLY_W-1:0]  dly_ns;
  logic [FRAC_W-1:0] dly_frac;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_full, fifo_empty, pop_req, ovf_set;
  logic              rdo_valid;
  logic [WORD_W-1:0] word0, word1, word2, word3;

  always_comb begin
    raw_entry.domain   = cap_domain;
    raw_entry.msg_type = cap_msg_type;
    raw_entry.seq_id   = cap_seq_id;
    raw_entry.sec      = cap_sec;
    raw_entry.nsec     = cap_nsec;
  end

  assign ovf_set = cap_valid && fifo_full;

  ets_delay_add u_dly (
    .raw_i      (raw_entry),
    .raw_frac_i (cap_subns),
    .dly_ns_i   (dly_ns),
    .dly_frac_i (dly_frac),
    .adj_o      (adj_entry)
  );

  ets_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (cap_valid),
    .din_i   (adj_entry),
    .pop_i   (pop_req),
    .head_o  (head_entry),
    .cnt_o   (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  ets_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .fifo_empty_i (fifo_empty),
    .head_i       (head_entry),
    .ovf_set_i    (ovf_set),
    .pop_o        (pop_req),
    .dly_ns_o     (dly_ns),
    .dly_frac_o   (dly_frac),
    .rdo_valid_o  (rdo_valid),
    .word0_o      (word0),
    .word1_o      (word1),
    .word2_o      (word2),
    .word3_o      (word3),
    .host_rdata   (host_rdata),
    .irq_o        (irq)
  );
endmodule

// File: rtl/ets_checker.sv
module ets_checker #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input logic             clk,
  input logic             rst_n,
  input logic             cap_valid,
  input logic             host_wr,
  input logic [3:0]       host_addr,
  input logic             irq,
  input logic             pop_req,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             fifo_full,
  input logic             rdo_valid,
  input logic [15:0]      word0,
  input logic [15:0]      word1,
  input logic [15:0]      word2,
  input logic [15:0]      word3
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH)); // R9

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == $past(fifo_cnt)) || (fifo_cnt == $past(fifo_cnt) + 1'b1)
    || (fifo_cnt + 1'b1 == $past(fifo_cnt))); // R11

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && fifo_full && !pop_req) |=> (fifo_cnt == $past(fifo_cnt))); // R9

  AST_CAPTURE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !fifo_full && !pop_req) |=> (fifo_cnt == $past(fifo_cnt) + 1'b1)); // R11

  AST_IRQ_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fifo_cnt != '0)); // R5

  AST_IRQ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !pop_req && !(host_wr && host_addr == 4'd5)) |=> irq); // R5

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdo_valid |-> (word0 == 16'h0 && word1 == 16'h0 && word2 == 16'h0 && word3 == 16'h0)); // R4
endmodule

bind egress_ts_fifo ets_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_valid (cap_valid),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .irq       (irq),
  .pop_req   (pop_req),
  .fifo_cnt  (fifo_cnt),
  .fifo_full (fifo_full),
  .rdo_valid (rdo_valid),
  .word0     (word0),
  .word1     (word1),
  .word2     (word2),
  .word3     (word3)
);

// File: tb/tb_egress_ts_fifo.sv
`timescale 1ns/1ps
module tb_egress_ts_fifo;
  logic        clk, rst_n;
  logic        cap_valid;
  logic [7:0]  cap_domain;
  logic [3:0]  cap_msg_type;
  logic [15:0] cap_seq_id;
  logic [4:0]  cap_sec;
  logic [29:0] cap_nsec;
  logic [15:0] cap_subns;
  logic        host_wr;
  logic [3:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        irq;

  int n_chk, n_fail;

  egress_ts_fifo dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0]  dom;
    logic [3:0]  typ;
    logic [15:0] seq;
    logic [4:0]  sec;
    logic [29:0] ns;
    logic [15:0] frac;
    logic [15:0] dns;
    logic [15:0] dfrac;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{8'h01, 4'h2, 16'h0001, 5'd3,  30'd1000,      16'h0000, 16'd0,  16'h0000},
    '{8'h7F, 4'h9, 16'hABCD, 5'd31, 30'd999999990, 16'h0000, 16'd5,  16'h0000},
    '{8'h02, 4'h3, 16'h1234, 5'd31, 30'd999999990, 16'h0000, 16'd20, 16'h0000},
    '{8'hFF, 4'hF, 16'hFFFF, 5'd12, 30'd536936447, 16'h8000, 16'd0,  16'h8000},
    '{8'h10, 4'h0, 16'h0000, 5'd4,  30'd65535,     16'hFFFF, 16'd1,  16'h0001},
    '{8'h00, 4'h1, 16'h8000, 5'd0,  30'd0,         16'h1234, 16'd0,  16'h0000}
  };

  function automatic logic [63:0] exp_words(vec_t v);
    longint     ns;
    logic [4:0] s;
    logic [16:0] fs;
    fs = {1'b0, v.frac} + {1'b0, v.dfrac};
    ns = longint'(v.ns) + longint'(v.dns) + longint'(fs[16]);
    s  = v.sec;
    if (ns >= 64'd1000000000) begin
      ns = ns - 64'd1000000000;
      s  = s + 5'd1;
    end
    return {s[1:0], ns[29:16], ns[15:0], v.seq, 1'b1, s[4:2], v.typ, v.dom};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic hread(logic [3:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic read_words(output logic [63:0] w);
    logic [15:0] a, b, c, e;
    hread(4'd0, a); hread(4'd1, b); hread(4'd2, c); hread(4'd3, e);
    w = {e, c, b, a};
  endtask

  task automatic capture(vec_t v);
    @(negedge clk);
    cap_valid = 1'b1; cap_domain = v.dom; cap_msg_type = v.typ;
    cap_seq_id = v.seq; cap_sec = v.sec; cap_nsec = v.ns; cap_subns = v.frac;
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  function automatic vec_t simple(logic [15:0] seq);
    vec_t v;
    v = '{8'h05, 4'h1, seq, 5'd2, 30'd777, 16'h0, 16'h0, 16'h0};
    return v;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] w;
    logic [15:0] d;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cap_valid = 1'b0; cap_domain = '0; cap_msg_type = '0;
    cap_seq_id = '0; cap_sec = '0; cap_nsec = '0; cap_subns = '0;
    host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_words(w);    chk("R1 words", w, 64'h0);
    chk("R1 irq", {63'b0, irq}, 64'h0);
    hread(4'd5, d);   chk("R1 irq_en", {48'b0, d}, 64'h0);
    hread(4'd6, d);   chk("R1 status", {48'b0, d}, 64'h0);
    hread(4'd7, d);   chk("R1 dly_ns", {48'b0, d}, 64'h0);
    hread(4'd8, d);   chk("R1 dly_frac", {48'b0, d}, 64'h0);

    // table walk: R2 R3 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      hwrite(4'd7, VEC[i].dns);
      hwrite(4'd8, VEC[i].dfrac);
      capture(VEC[i]);
      hread(4'd6, d); chk("R6 status nonempty", {63'b0, d[0]}, 64'h1);
      hwrite(4'd4, 16'h1);
      read_words(w);
      chk($sformatf("R2 R3 R7 R8 vector %0d", i), w, exp_words(VEC[i]));
    end
    hwrite(4'd7, 16'h0);
    hwrite(4'd8, 16'h0);
    hwrite(4'd4, 16'h1);
    read_words(w); chk("R4 empty after drain", w, 64'h0);

    // R5 interrupt level, order R4
    hwrite(4'd5, 16'h1);
    chk("R5 irq low when empty", {63'b0, irq}, 64'h0);
    capture(simple(16'h0A01));
    chk("R5 irq high after capture", {63'b0, irq}, 64'h1);
    capture(simple(16'h0A02));
    capture(simple(16'h0A03));
    hwrite(4'd4, 16'h1);
    hread(4'd1, d); chk("R4 order first", {48'b0, d}, 64'h0A01);
    chk("R5 irq held with entries left", {63'b0, irq}, 64'h1);
    hwrite(4'd4, 16'h1);
    hread(4'd1, d); chk("R4 order second", {48'b0, d}, 64'h0A02);
    hwrite(4'd4, 16'h1);
    hread(4'd1, d); chk("R4 order third", {48'b0, d}, 64'h0A03);
    chk("R5 irq low once drained", {63'b0, irq}, 64'h0);
    // R10: done bit clear has no effect
    hwrite(4'd4, 16'hFFFE);
    hread(4'd1, d); chk("R10 readout kept", {48'b0, d}, 64'h0A03);
    hread(4'd0, d); chk("R10 valid kept", {63'b0, d[15]}, 64'h1);
    hwrite(4'd4, 16'h1);
    read_words(w); chk("R4 empty words zero", w, 64'h0);

    // R9 overflow with interrupt disabled
    hwrite(4'd5, 16'h0);
    for (int k = 1; k <= 5; k++) capture(simple(16'hB000 + 16'(k)));
    chk("R5 irq gated by enable", {63'b0, irq}, 64'h0);
    hread(4'd6, d); chk("R9 status ovf and nonempty", {48'b0, d}, 64'h3);
    hwrite(4'd6, 16'h1);
    hread(4'd6, d); chk("R9 ovf survives write of bit1=0", {63'b0, d[1]}, 64'h1);
    for (int k = 1; k <= 4; k++) begin
      hwrite(4'd4, 16'h1);
      hread(4'd1, d); chk("R9 kept entry", {48'b0, d}, {48'b0, 16'hB000 + 16'(k)});
    end
    hwrite(4'd4, 16'h1);
    hread(4'd0, d); chk("R9 dropped entry absent", {48'b0, d}, 64'h0);
    hwrite(4'd6, 16'h2);
    hread(4'd6, d); chk("R9 ovf cleared", {48'b0, d}, 64'h0);

    // R11 capture and done in the same cycle, FIFO empty beforehand
    capture(simple(16'hC001));
    hwrite(4'd4, 16'h1);
    hread(4'd1, d); chk("R11 setup", {48'b0, d}, 64'hC001);
    @(negedge clk);
    cap_valid = 1'b1; cap_seq_id = 16'hC002; cap_domain = 8'h05; cap_msg_type = 4'h1;
    cap_sec = 5'd2; cap_nsec = 30'd777; cap_subns = 16'h0;
    host_wr = 1'b1; host_addr = 4'd4; host_wdata = 16'h1;
    @(negedge clk);
    cap_valid = 1'b0; host_wr = 1'b0;
    read_words(w); chk("R11 done saw empty FIFO", w, 64'h0);
    hread(4'd6, d); chk("R11 capture queued", {63'b0, d[0]}, 64'h1);
    hwrite(4'd4, 16'h1);
    hread(4'd1, d); chk("R11 captured entry", {48'b0, d}, 64'hC002);

    summary();
    $finish;
  end
endmodule